// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is the control and status register bank of a processor core module. It sits on a simple word-addressed bus with one access per cycle and no handshake. It holds a fixed identity word and a fixed status word. It also holds two clock-setting registers, a control register, a memory-timing word, an initialisation word, two banks of flags and a free-running reference counter. Finally, it gives a read-only view into part of a 128-byte memory-presence descriptor table.

The clock-setting registers are guarded by a key. Writes to them only land while a 16-bit magic value is held in the lock register. The flag banks have one address for setting bits and one for clearing them. The control register drives two outputs. One is a remap level that takes the boot flash away from address zero. The other is a reset-request pulse that is never stored. The reference counter advances once per cycle of an enable input. That input is meant to come from a prescaler that produces the reference rate.

Top module: `sysctl_regbank`

## Requirements
- R1: Word 0 (byte address 0x000) always reads 0x411A3001. Word 4 (0x010) always reads 0x00100000. Writes to either are rejected (error strobe) and do not change the value read.
- R2: The lock register (0x014) keeps only bits [15:0] of a write. While it holds 0xA05F it reads 0x0001A05F. Otherwise it reads the stored 16-bit value, zero-extended.
- R3: Writes to the oscillator word (0x008) and the auxiliary oscillator word (0x01C) take effect only while the lock holds 0xA05F. At any other time they are ignored.
- R4: In the control word (0x00C), only bits 0 and 2 are stored. Every other bit, bit 3 included, reads as zero.
- R5: A write to the control word with bit 3 set raises `reset_req_o` for exactly one cycle, starting the cycle after the write. A second request while the pulse is high is merged into it.
- R6: `boot_remap_o` follows control bit 2. A value of 0 means boot flash at address zero; a value of 1 means flash disabled there and RAM visible instead.
- R7: The flag word reads at 0x030. A write there ORs the data into it. A write to 0x034 clears every bit that is 1 in the data.
- R8: The non-volatile flag word behaves the same way: it reads and sets at 0x038 and clears at 0x03C.
- R9: The 32-bit reference counter (0x028) is 0 after reset. It increments once on each clock with `ref_tick_i` high and holds otherwise. A read returns the value from before the access edge.
- R10: After reset the registers read as follows:
  - oscillator: 0x01000048
  - auxiliary oscillator: 0x0007FEFF
  - init (0x024): 0x00000112
  - SDRAM (0x020): 0x00011122 ORed with a size code, which is 0x10 for MEM_MB≥256, 0x0C for ≥128, 0x08 for ≥64, 0x04 for ≥32, and 0 below that.
  - lock, control and both flag words: 0.
  
  The SDRAM and init words are freely writable.
- R11: Byte addresses 0x100–0x17F read table byte number (address>>2), zero-extended. Table bytes 73–83 hold the ASCII text "GENERIC-MEM" and the other bytes in that range are 0. Addresses 0x180–0x1FF read 0. The window is read-only.
- R12: Any access with no handler for its direction raises `bus_err_o`, reads 0 and changes no state. This covers unlisted offsets, addresses at 0x200 and above, writes to read-only words and reads of the two clear addresses. Read data and the error strobe appear in the cycle after the access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Reference counter enable (prescaler output) |
| bus_sel_i | input | 1 | Access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_err_o | output | 1 | Registered error strobe for the previous access |
| boot_remap_o | output | 1 | 1 = boot flash removed from address zero |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `bus_sel_i`, `bus_wr_i`, the address and the write data are settled before each rising edge and remain valid for the whole cycle. They also assume that `ref_tick_i` is a clean level that is sampled on the same edge. The bench drives every input on the falling edge and drops the select shortly after the rising edge. As a result, each access occupies exactly one sampled edge, and the counter enable only changes while no counter read is in flight. This keeps the counter value it predicts exact.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam logic [31:0] ID_WORD     = 32'h411A_3001;
    localparam logic [31:0] STAT_WORD   = 32'h0010_0000;
    localparam logic [15:0] LOCK_KEY    = 16'hA05F;
    localparam logic [31:0] OSC_RST     = 32'h0100_0048;
    localparam logic [31:0] AUX_RST     = 32'h0007_FEFF;
    localparam logic [31:0] INIT_RST    = 32'h0000_0112;
    localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;
    localparam int          NAME_FIRST  = 73;
    localparam int          NAME_LEN    = 11;
    localparam logic [8*NAME_LEN-1:0] DESC_NAME = "GENERIC-MEM";

    typedef enum logic [3:0] {
        RID_NONE, RID_ID, RID_OSC, RID_CTRL, RID_STAT, RID_LOCK, RID_AUX,
        RID_SDRAM, RID_INIT, RID_CNT, RID_FLG, RID_FLGC, RID_NV, RID_NVC,
        RID_DESC
    } reg_id_e;

    function automatic logic [31:0] sdram_reset(input int mem_mb);
        logic [31:0] code;
        if (mem_mb >= 256)      code = 32'h10;
        else if (mem_mb >= 128) code = 32'h0C;
        else if (mem_mb >= 64)  code = 32'h08;
        else if (mem_mb >= 32)  code = 32'h04;
        else                    code = 32'h00;
        return SDRAM_BASE | code;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_id_e           reg_id_o,
    output logic              acc_ok_o
);
    localparam int WIN_BIT = 8;

    always_comb begin
        reg_id_o = RID_NONE;
        if (addr_i[ADDR_W-1:WIN_BIT+1] == '0) begin
            if (addr_i[WIN_BIT]) begin
                reg_id_o = RID_DESC;
            end else begin
                case (addr_i[WIN_BIT-1:2])
                    6'd0:    reg_id_o = RID_ID;
                    6'd2:    reg_id_o = RID_OSC;
                    6'd3:    reg_id_o = RID_CTRL;
                    6'd4:    reg_id_o = RID_STAT;
                    6'd5:    reg_id_o = RID_LOCK;
                    6'd7:    reg_id_o = RID_AUX;
                    6'd8:    reg_id_o = RID_SDRAM;
                    6'd9:    reg_id_o = RID_INIT;
                    6'd10:   reg_id_o = RID_CNT;
                    6'd12:   reg_id_o = RID_FLG;
                    6'd13:   reg_id_o = RID_FLGC;
                    6'd14:   reg_id_o = RID_NV;
                    6'd15:   reg_id_o = RID_NVC;
                    default: reg_id_o = RID_NONE;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_id_o)
            RID_NONE:                            acc_ok_o = 1'b0;
            RID_ID, RID_STAT, RID_CNT, RID_DESC: acc_ok_o = !wr_i;
            RID_FLGC, RID_NVC:                   acc_ok_o = wr_i;
            default:                             acc_ok_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sysctl_desc_rom.sv
module sysctl_desc_rom
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);
    localparam int NAME_LAST = NAME_FIRST + NAME_LEN - 1;

    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < NAME_LEN; k++) begin
            if (int'(idx_i) == NAME_FIRST + k)
                byte_o = DESC_NAME[8*(NAME_LEN-1-k) +: 8];
        end
    end

    initial begin
        if (NAME_LAST >= (1 << IDX_W)) $error("descriptor name exceeds table");
    end
endmodule

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R9
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R9
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MEM_MB = 128,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_err_o,
    output logic              boot_remap_o,
    output logic              reset_req_o
);
    localparam int          IDX_W       = 7;
    localparam logic [31:0] SDRAM_RST   = sdram_reset(MEM_MB);
    localparam int          CTRL_LED    = 0;
    localparam int          CTRL_REMAP  = 2;
    localparam int          CTRL_RESET  = 3;

    typedef struct packed {
        logic [31:0] osc;
        logic [31:0] aux;
        logic [31:0] sdram;
        logic [31:0] init;
        logic [31:0] flags;
        logic [31:0] nvflags;
        logic [15:0] lock;
        logic        led;
        logic        remap;
        logic        rst_req;
        logic [31:0] rdata;
        logic        err;
    } state_t;

    state_t          st_d, st_q;
    reg_id_e         reg_id;
    logic            acc_ok;
    logic [7:0]      desc_byte;
    logic [CNT_W-1:0] ref_count;
    logic            unlocked;

    sysctl_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .reg_id_o (reg_id),
        .acc_ok_o (acc_ok)
    );

    sysctl_desc_rom #(.IDX_W(IDX_W)) rom_i (
        .idx_i  (bus_addr_i[IDX_W+1:2]),
        .byte_o (desc_byte)
    );

    sysctl_refcnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (ref_tick_i),
        .count_o (ref_count)
    );

    assign unlocked = (st_q.lock == LOCK_KEY);

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        st_d.rdata   = '0;
        st_d.err     = 1'b0;
        if (bus_sel_i) begin
            if (!acc_ok) begin
                st_d.err = 1'b1;
            end else if (bus_wr_i) begin
                case (reg_id)
                    RID_OSC:   if (unlocked) st_d.osc = bus_wdata_i;
                    RID_AUX:   if (unlocked) st_d.aux = bus_wdata_i;
                    RID_CTRL: begin
                        st_d.led     = bus_wdata_i[CTRL_LED];
                        st_d.remap   = bus_wdata_i[CTRL_REMAP];
                        st_d.rst_req = bus_wdata_i[CTRL_RESET] && !st_q.rst_req;
                    end
                    RID_LOCK:  st_d.lock    = bus_wdata_i[15:0];
                    RID_SDRAM: st_d.sdram   = bus_wdata_i;
                    RID_INIT:  st_d.init    = bus_wdata_i;
                    RID_FLG:   st_d.flags   = st_q.flags | bus_wdata_i;
                    RID_FLGC:  st_d.flags   = st_q.flags & ~bus_wdata_i;
                    RID_NV:    st_d.nvflags = st_q.nvflags | bus_wdata_i;
                    RID_NVC:   st_d.nvflags = st_q.nvflags & ~bus_wdata_i;
                    default: ;
                endcase
            end else begin
                case (reg_id)
                    RID_ID:    st_d.rdata = ID_WORD;
                    RID_STAT:  st_d.rdata = STAT_WORD;
                    RID_OSC:   st_d.rdata = st_q.osc;
                    RID_AUX:   st_d.rdata = st_q.aux;
                    RID_CTRL: begin
                        st_d.rdata[CTRL_LED]   = st_q.led;
                        st_d.rdata[CTRL_REMAP] = st_q.remap;
                    end
                    RID_LOCK:  st_d.rdata = {15'd0, unlocked, st_q.lock};
                    RID_SDRAM: st_d.rdata = st_q.sdram;
                    RID_INIT:  st_d.rdata = st_q.init;
                    RID_CNT:   st_d.rdata = 32'(ref_count);
                    RID_FLG:   st_d.rdata = st_q.flags;
                    RID_NV:    st_d.rdata = st_q.nvflags;
                    RID_DESC:  if (!bus_addr_i[7]) st_d.rdata = {24'd0, desc_byte};
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.osc     <= OSC_RST;
            st_q.aux     <= AUX_RST;
            st_q.sdram   <= SDRAM_RST;
            st_q.init    <= INIT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o  = st_q.rdata;
    assign bus_err_o    = st_q.err;
    assign boot_remap_o = st_q.remap;
    assign reset_req_o  = st_q.rst_req;

    // R5
    rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_req_o |=> !reset_req_o);

    // R3
    osc_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_wr_i && acc_ok && (reg_id == RID_OSC) && !unlocked)
        |=> $stable(st_q.osc));

    // R7
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_wr_i && (reg_id == RID_FLGC))
        |=> ((st_q.flags & $past(bus_wdata_i)) == '0));

    // R12
    err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> (bus_rdata_o == '0));

    // R2
    lock_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i && (reg_id == RID_LOCK))
        |=> (bus_rdata_o[31:17] == '0));
endmodule

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;

    typedef struct {
        logic [31:0] data;
        logic        chk_data;
        logic        err;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              err;
    logic              remap;
    logic              rst_req;

    exp_t exp_q[$];
    logic pending = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regbank #(.ADDR_W(ADDR_W), .MEM_MB(128)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err),
        .boot_remap_o(remap), .reset_req_o(rst_req)
    );

    always @(posedge clk) pending <= sel && rst_n;

    // monitor: compares registered results against queued expectations
    always @(negedge clk) begin
        if (pending && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (err !== e.err || (e.chk_data && rdata !== e.data)) begin
                n_fail++;
                $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                         e.tag, rdata, err, e.data, e.err);
            end
        end
    end

    task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input logic [31:0] exp_d,
                          input logic chk, input logic exp_err, input string tag);
        exp_t e;
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        e.data = exp_d; e.chk_data = chk; e.err = exp_err; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp_d,
                      input string tag);
        access(1'b0, a, 32'd0, exp_d, 1'b1, 1'b0, tag);
    endtask

    task automatic wrt(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input string tag);
        access(1'b1, a, d, 32'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R1 constants
        check_bit(remap, 1'b0, "R10 remap after reset");
        check_bit(rst_req, 1'b0, "R10 reset_req after reset");
        rd(12'h000, 32'h411A3001, "R1 id word");
        rd(12'h010, 32'h00100000, "R1 status word");
        rd(12'h008, 32'h01000048, "R10 osc reset");
        rd(12'h01C, 32'h0007FEFF, "R10 aux reset");
        rd(12'h024, 32'h00000112, "R10 init reset");
        rd(12'h020, 32'h0001112E, "R10 sdram reset with 128MB code");
        rd(12'h014, 32'h0, "R10 lock reset");
        rd(12'h030, 32'h0, "R10 flags reset");
        rd(12'h038, 32'h0, "R10 nvflags reset");
        rd(12'h028, 32'h0, "R9 counter at reset");
        // R3 locked writes ignored
        wrt(12'h008, 32'h12345678, "R3 osc write locked");
        wrt(12'h01C, 32'h0000BEEF, "R3 aux write locked");
        rd(12'h008, 32'h01000048, "R3 osc unchanged while locked");
        rd(12'h01C, 32'h0007FEFF, "R3 aux unchanged while locked");
        // R2 unlock with upper junk
        wrt(12'h014, 32'h1234A05F, "R2 lock write");
        rd(12'h014, 32'h0001A05F, "R2 lock unlocked readback");
        wrt(12'h008, 32'h12345678, "R3 osc write unlocked");
        wrt(12'h01C, 32'h00ABCDEF, "R3 aux write unlocked");
        rd(12'h008, 32'h12345678, "R3 osc updated");
        rd(12'h01C, 32'h00ABCDEF, "R3 aux updated");
        wrt(12'h014, 32'hFFFFBEEF, "R2 relock");
        rd(12'h014, 32'h0000BEEF, "R2 lock plain readback");
        wrt(12'h008, 32'h0, "R3 osc write relocked");
        rd(12'h008, 32'h12345678, "R3 osc held after relock");
        // R4 R5 R6 control
        wrt(12'h00C, 32'hFFFFFFFF, "R4 ctrl write all ones");
        @(negedge clk);
        check_bit(rst_req, 1'b1, "R5 reset pulse high");
        check_bit(remap, 1'b1, "R6 remap set");
        @(negedge clk);
        check_bit(rst_req, 1'b0, "R5 reset pulse one cycle");
        rd(12'h00C, 32'h00000005, "R4 ctrl keeps bits 0 and 2 only");
        wrt(12'h00C, 32'h00000001, "R6 ctrl clear remap");
        @(negedge clk);
        check_bit(remap, 1'b0, "R6 remap cleared");
        check_bit(rst_req, 1'b0, "R5 no pulse without bit 3");
        rd(12'h00C, 32'h00000001, "R4 ctrl readback led only");
        // R7 flags
        wrt(12'h030, 32'h000000F0, "R7 flag set 1");
        wrt(12'h030, 32'h00000101, "R7 flag set 2");
        rd(12'h030, 32'h000001F1, "R7 flags ORed");
        wrt(12'h034, 32'h00000011, "R7 flag clear");
        rd(12'h030, 32'h000001E0, "R7 flags after clear");
        // R8 nv flags
        wrt(12'h038, 32'h80000003, "R8 nv set");
        wrt(12'h03C, 32'h00000002, "R8 nv clear");
        rd(12'h038, 32'h80000001, "R8 nv result");
        rd(12'h030, 32'h000001E0, "R8 flags untouched by nv");
        // R10 writable sdram/init
        wrt(12'h020, 32'hCAFE0001, "R10 sdram write");
        wrt(12'h024, 32'h00000077, "R10 init write");
        rd(12'h020, 32'hCAFE0001, "R10 sdram readback");
        rd(12'h024, 32'h00000077, "R10 init readback");
        // R9 counter
        @(negedge clk);
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        rd(12'h028, 32'd5, "R9 counter after five ticks");
        rd(12'h028, 32'd5, "R9 counter holds");
        // R11 window
        rd(12'h124, 32'h47, "R11 first name byte");
        rd(12'h128, 32'h45, "R11 second name byte");
        rd(12'h14C, 32'h4D, "R11 last name byte");
        rd(12'h150, 32'h0, "R11 byte past name");
        rd(12'h100, 32'h0, "R11 window start");
        rd(12'h180, 32'h0, "R11 upper half zero");
        rd(12'h1FC, 32'h0, "R11 window end zero");
        access(1'b1, 12'h124, 32'hFF, 32'h0, 1'b0, 1'b1, "R11 window write rejected");
        // R12 / R1 errors
        access(1'b0, 12'h004, 32'h0, 32'h0, 1'b1, 1'b1, "R12 unlisted read");
        access(1'b0, 12'h034, 32'h0, 32'h0, 1'b1, 1'b1, "R12 read of clear address");
        access(1'b0, 12'h200, 32'h0, 32'h0, 1'b1, 1'b1, "R12 read above window");
        access(1'b1, 12'h0FC, 32'h1, 32'h0, 1'b0, 1'b1, "R12 unlisted write");
        access(1'b1, 12'h000, 32'h0, 32'h0, 1'b0, 1'b1, "R1 id write rejected");
        access(1'b1, 12'h010, 32'h0, 32'h0, 1'b0, 1'b1, "R1 status write rejected");
        access(1'b1, 12'h028, 32'h0, 32'h0, 1'b0, 1'b1, "R12 counter write rejected");
        rd(12'h000, 32'h411A3001, "R1 id unchanged");
        rd(12'h028, 32'd5, "R12 counter unchanged by write");
        rd(12'h030, 32'h000001E0, "R12 state untouched by bad writes");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule